// File: doc/BRIEF.md
# Stereo Receive Status Flag Controller

This block holds the status and interrupt state for a two-channel serial audio receiver. A shift register outside the block pulses a word-transfer strobe each time a finished word lands in the receive data register. At that moment the block reads the word-select level and decides whether the word belongs to the left or the right channel. It then sets the matching full flag. A polarity bit picks which word-select level means left.

In normal streaming, the two flags take turns: a left word arrives and is read, then a right word arrives and is read. When both flags are set, software has fallen behind and the block reports overrun. Leaving overrun takes two steps in order: a status-register read, then a later (or same-cycle, if already armed) data-register read. A data read on its own, or a status read taken before overrun began, does not clear the flags.

The interrupt request is a level output. A second output tells the interrupt logic whether the normal or the overrun service vector applies. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure. Every strobe is a single-cycle pulse on the system clock.

Top module: `srx_status_ctrl`

## Requirements
- R1: A word transfer with ws_level equal to ws_polarity is a left word; it sets left_full at the next clock edge.
- R2: A word transfer with ws_level different from ws_polarity is a right word; it sets right_full at the next clock edge.
- R3: overrun is high exactly when left_full and right_full are both high.
- R4: With exactly one flag set, a data_rd pulse clears that flag at the next edge.
- R5: In overrun, a data_rd pulse that no earlier in-overrun stat_rd has armed leaves both flags set.
- R6: In overrun, a stat_rd pulse arms the clear; a data_rd in a later cycle then clears both flags. A stat_rd taken while not in overrun does not arm.
- R7: soft_rst, stop_mode, or all bits of rx_en low clears both flags and the arming at the next edge. While any of these holds, word transfers do not set flags.
- R8: When a word transfer and a data_rd fall in the same cycle, the flag set by the new word ends up set.
- R9: irq_req is high exactly when irq_en is high and at least one flag is set. irq_ovr_vec is high exactly when overrun holds.
- R10: After hardware reset (rst_n low), all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset level |
| stop_mode | input | 1 | Stop state active; clears the flags |
| rx_en | input | NUM_RX | Receiver enable bits |
| ws_polarity | input | 1 | Word-select level that marks a left word |
| ws_level | input | 1 | Word-select level at the transfer |
| word_xfer | input | 1 | Pulse: word moved into the receive data register |
| stat_rd | input | 1 | Pulse: status register read |
| data_rd | input | 1 | Pulse: receive data register read |
| irq_en | input | 1 | Receive interrupt enable |
| left_full | output | 1 | Left word waiting |
| right_full | output | 1 | Right word waiting |
| overrun | output | 1 | Both flags set |
| irq_req | output | 1 | Interrupt request level |
| irq_ovr_vec | output | 1 | Selects the overrun vector when high |

## Verification
Directed runs cover these cases:
- Plain alternating left and right traffic under both polarities. This separates a correct side decode from an inverted one.
- Overrun entry followed by data reads with and without a preceding status read. This separates the two-step clear from a single-read clear.
- A status read taken before overrun begins, which must not arm the clear.
- Same-cycle transfer-plus-read collisions, which show whether the set or the clear wins.

Seeded random traffic then mixes strobes, enable drops, stop and software reset. A bench model follows every cycle of that traffic and catches ordering faults that the directed cases miss.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic left;
    logic right;
  } srx_flags_t;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } srx_side_e;
endpackage

// File: rtl/srx_side_decode.sv
module srx_side_decode
  import srx_pkg::*;
(
  input  logic ws_level,
  input  logic ws_polarity,
  input  logic word_xfer,
  output logic set_left,
  output logic set_right
);
  srx_side_e side;

  always_comb begin
    side      = (ws_level == ws_polarity) ? SIDE_LEFT : SIDE_RIGHT;
    set_left  = word_xfer && (side == SIDE_LEFT);
    set_right = word_xfer && (side == SIDE_RIGHT);
  end
endmodule

// File: rtl/srx_flag_core.sv
module srx_flag_core
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic       set_left,
  input  logic       set_right,
  input  logic       stat_rd,
  input  logic       data_rd,
  output srx_flags_t flags,
  output logic       armed
);
  srx_flags_t flags_n;
  logic       armed_n;
  logic       both;

  assign both = flags.left && flags.right;

  always_comb begin
    flags_n = flags;
    armed_n = armed;
    if (both) begin
      if (data_rd && armed) begin
        flags_n = '0;
        armed_n = 1'b0;
      end else if (stat_rd) begin
        armed_n = 1'b1;
      end
    end else if (data_rd) begin
      flags_n = '0;
    end
    if (set_left)  flags_n.left  = 1'b1;
    if (set_right) flags_n.right = 1'b1;
    if (kill) begin
      flags_n = '0;
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= 1'b0;
    end else begin
      flags <= flags_n;
      armed <= armed_n;
    end
  end

  assert_left_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_left && !kill) |=> flags.left);
  assert_right_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_right && !kill) |=> flags.right);
  assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags.left ^ flags.right) && data_rd && !set_left && !set_right && !kill)
      |=> (!flags.left && !flags.right));
  assert_unarmed_read_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !armed && data_rd && !kill) |=> (flags.left && flags.right));
  assert_armed_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (both && armed && data_rd && !kill && !set_left && !set_right)
      |=> (!flags.left && !flags.right && !armed));
  assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!flags.left && !flags.right && !armed));
endmodule

// File: rtl/srx_irq_gen.sv
module srx_irq_gen
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  srx_flags_t flags,
  input  logic       irq_en,
  output logic       irq_req,
  output logic       irq_ovr_vec
);
  logic any_full;

  always_comb begin
    any_full    = flags.left || flags.right;
    irq_req     = irq_en && any_full;
    irq_ovr_vec = flags.left && flags.right;
  end

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_en);
endmodule

// File: rtl/srx_status_ctrl.sv
module srx_status_ctrl
  import srx_pkg::*;
#(
  parameter int NUM_RX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_mode,
  input  logic [NUM_RX-1:0] rx_en,
  input  logic              ws_polarity,
  input  logic              ws_level,
  input  logic              word_xfer,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              irq_en,
  output logic              left_full,
  output logic              right_full,
  output logic              overrun,
  output logic              irq_req,
  output logic              irq_ovr_vec
);
  srx_flags_t flags;
  logic       armed;
  logic       kill;
  logic       set_left;
  logic       set_right;

  assign kill = soft_rst || stop_mode || (rx_en == '0);

  srx_side_decode u_side (
    .ws_level    (ws_level),
    .ws_polarity (ws_polarity),
    .word_xfer   (word_xfer),
    .set_left    (set_left),
    .set_right   (set_right)
  );

  srx_flag_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .set_left  (set_left),
    .set_right (set_right),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .flags     (flags),
    .armed     (armed)
  );

  srx_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags       (flags),
    .irq_en      (irq_en),
    .irq_req     (irq_req),
    .irq_ovr_vec (irq_ovr_vec)
  );

  assign left_full  = flags.left;
  assign right_full = flags.right;
  assign overrun    = flags.left && flags.right;

  assert_vec_tracks_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr_vec |-> (left_full && right_full));
  assert_armed_only_in_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> overrun);
endmodule

// File: tb/tb_srx_status_ctrl.sv
module tb_srx_status_ctrl;
  localparam int NUM_RX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, stop_mode = 1'b0;
  logic [NUM_RX-1:0] rx_en = '1;
  logic ws_polarity = 1'b0, ws_level = 1'b0;
  logic word_xfer = 1'b0, stat_rd = 1'b0, data_rd = 1'b0, irq_en = 1'b1;
  logic left_full, right_full, overrun, irq_req, irq_ovr_vec;

  int checks = 0;
  int errors = 0;
  logic ml = 1'b0, mr = 1'b0, marm = 1'b0;

  always #2 clk = ~clk;

  srx_status_ctrl #(.NUM_RX(NUM_RX)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_mode(stop_mode),
    .rx_en(rx_en), .ws_polarity(ws_polarity), .ws_level(ws_level),
    .word_xfer(word_xfer), .stat_rd(stat_rd), .data_rd(data_rd), .irq_en(irq_en),
    .left_full(left_full), .right_full(right_full), .overrun(overrun),
    .irq_req(irq_req), .irq_ovr_vec(irq_ovr_vec)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] model_next(input logic l, input logic r, input logic a);
    logic nl, nr, na;
    nl = l; nr = r; na = a;
    if (l && r) begin
      if (data_rd && a) begin nl = 0; nr = 0; na = 0; end
      else if (stat_rd) na = 1;
    end else if (data_rd) begin
      nl = 0; nr = 0;
    end
    if (word_xfer) begin
      if (ws_level == ws_polarity) nl = 1; else nr = 1;
    end
    if (soft_rst || stop_mode || rx_en == '0) begin nl = 0; nr = 0; na = 0; end
    return {nl, nr, na};
  endfunction

  task automatic tick();
    logic [2:0] n;
    @(posedge clk);
    n = model_next(ml, mr, marm);
    {ml, mr, marm} = n;
    #1;
    chk("R1/R2/R4-R8 flags", {2'b00, left_full, right_full}, {2'b00, ml, mr});
    chk("R3 overrun", {3'b000, overrun}, {3'b000, ml & mr});
    chk("R9 irq", {2'b00, irq_req, irq_ovr_vec}, {2'b00, irq_en & (ml | mr), ml & mr});
    word_xfer = 0; stat_rd = 0; data_rd = 0;
  endtask

  task automatic word(input logic left);
    word_xfer = 1; ws_level = left ? ws_polarity : ~ws_polarity; tick();
  endtask
  task automatic drd(); data_rd = 1; tick(); endtask
  task automatic srd(); stat_rd = 1; tick(); endtask
  task automatic clear_all(); soft_rst = 1; tick(); soft_rst = 0; endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    #5;
    chk("R10 reset", {left_full, right_full, overrun, irq_req}, 4'b0000);
    chk("R10 reset vec", {3'b000, irq_ovr_vec}, 4'b0000);
    @(negedge clk); rst_n = 1;

    // R1 / R2 under both polarities, R4 single clears
    word(1); chk("R1 left set", {2'b00, left_full, right_full}, 4'b0010);
    drd();   chk("R4 left clear", {2'b00, left_full, right_full}, 4'b0000);
    word(0); chk("R2 right set", {2'b00, left_full, right_full}, 4'b0001);
    drd();
    ws_polarity = 1;
    word_xfer = 1; ws_level = 1; tick();
    chk("R1 polarity high left", {2'b00, left_full, right_full}, 4'b0010);
    drd();
    word_xfer = 1; ws_level = 0; tick();
    chk("R2 polarity high right", {2'b00, left_full, right_full}, 4'b0001);
    drd();
    ws_polarity = 0;

    // R3 / R5 / R6 / R9 overrun sequence
    word(1); word(0);
    chk("R3 overrun", {3'b000, overrun}, 4'b0001);
    chk("R9 overrun vector", {2'b00, irq_req, irq_ovr_vec}, 4'b0011);
    drd(); chk("R5 unarmed read keeps", {2'b00, left_full, right_full}, 4'b0011);
    srd(); drd(); chk("R6 two-step clear", {2'b00, left_full, right_full}, 4'b0000);

    // R6: status read before overrun does not arm
    word(1); srd(); word(0); drd();
    chk("R6 early status read ignored", {2'b00, left_full, right_full}, 4'b0011);
    clear_all();

    // R8: set wins over clear
    word(1); data_rd = 1; word(0);
    chk("R8 new right survives read", {2'b00, left_full, right_full}, 4'b0001);
    data_rd = 1; word(0);
    chk("R8 same side survives read", {2'b00, left_full, right_full}, 4'b0001);
    drd();

    // R7 stop, soft reset clears arming, disable
    word(1); word(0); stop_mode = 1; word(1); stop_mode = 0;
    chk("R7 stop clears", {2'b00, left_full, right_full}, 4'b0000);
    word(1); word(0); srd(); clear_all(); word(1); word(0); drd();
    chk("R7 arming cleared", {2'b00, left_full, right_full}, 4'b0011);
    rx_en = '0; tick(); rx_en = 2'b01;
    chk("R7 all disabled clears", {2'b00, left_full, right_full}, 4'b0000);

    // R9 enable low
    irq_en = 0; word(1);
    chk("R9 irq gated", {3'b000, irq_req}, 4'b0000);
    irq_en = 1; drd();

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      word_xfer   = (r < 40);
      ws_level    = $urandom_range(0, 1);
      stat_rd     = ($urandom_range(0, 99) < 25);
      data_rd     = ($urandom_range(0, 99) < 35);
      soft_rst    = ($urandom_range(0, 99) < 2);
      stop_mode   = ($urandom_range(0, 99) < 2);
      rx_en       = ($urandom_range(0, 99) < 3) ? '0 : NUM_RX'($urandom_range(1, 3));
      irq_en      = ($urandom_range(0, 99) < 85);
      if ($urandom_range(0, 99) < 2) ws_polarity = ~ws_polarity;
      tick();
      soft_rst = 0; stop_mode = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule